// File: doc/BRIEF.md
# Three-Trit Balanced Ternary Processor Core

This block is a very small processor whose data and addresses are balanced ternary. Each trit travels as a two-bit code. The program store has three slots, at trit addresses -1, 0 and +1. Each slot holds one 3-trit instruction word.

Around the core sit five state elements:
- an input register that the outside world writes (IN),
- an output register (OUT),
- an accumulator (A),
- a three-valued status trit (S),
- a one-trit program counter (PC).

While the core is held in reset, the program is written through a load port. After reset is released, every single-cycle step pulse executes exactly one instruction. The instruction set is compare, load immediate and branch-on-equal. All architectural registers are driven onto output ports so a surrounding system can observe them.

Top module: `tern_core`

## Requirements
- R1: While reset (`rst_n` low) is sampled at a clock edge, that edge sets PC to 0, S to +1, A to 0, OUT to 0 and IN to 0.
- R2: IN is written by `in_we` with the 4-bit two's complement `in_val`. This works on any non-reset cycle, whether or not a step occurs in that cycle. Values from -4 to +4 are stored. Any other value leaves IN unchanged. An instruction that executes in the same cycle reads the old IN.
- R3: The program store accepts a write only while `rst_n` is low. A `pm_we` pulse while running changes no stored instruction.
- R4: A load whose address or data contains the code 2'b10 is not stored. `pm_err` is 1 in the cycle after such a load, and 0 after any other cycle.
- R5: Trit codes are 2'b11 for -1, 2'b00 for 0 and 2'b01 for +1. An instruction word is {opcode[5:4], field1[3:2], field2[1:0]}. Register selectors map -1 to IN, 0 to OUT and +1 to A. Opcode -1 (compare) sets S to -1, 0 or +1 as the register named by field1 is less than, equal to or greater than the register named by field2, using signed comparison.
- R6: Opcode 0 (load immediate) writes A with 3·field1 + field2.
- R7: Opcode +1 (branch) sets PC to field1 when S is 0, and to field2 otherwise. It leaves A and S unchanged.
- R8: Compare and load immediate advance PC by one. An advance from +1 wraps to -1, so straight-line code visits 0, +1, -1, 0.
- R9: Without a step pulse, PC, A and S hold their values. OUT stays 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also enables program loading |
| step | input | 1 | Execute one instruction at this edge |
| in_we | input | 1 | Write strobe for IN |
| in_val | input | 4 | Signed value for IN |
| pm_we | input | 1 | Program store write strobe |
| pm_addr | input | 2 | Trit code of the slot to write |
| pm_data | input | 6 | Instruction word to store |
| pm_err | output | 1 | Previous load carried an invalid trit code |
| reg_in | output | 4 | IN register |
| reg_out | output | 4 | OUT register |
| reg_a | output | 4 | Accumulator |
| reg_s | output | 2 | Status trit code |
| pc | output | 2 | Program counter trit code |

## Verification
A wrong PC becomes visible on the `pc` port at the very next clock edge. It also selects the wrong slot, so one step later it shows up as the wrong A or S. A corrupted S changes `reg_s` at once. Its effect then spreads through the first branch that follows, which sends PC to the wrong field. The bench models every register at the ports cycle by cycle across random programs, step patterns and IN writes, so any divergence is reported within one cycle of its cause.

// File: rtl/tern_pkg.sv
// Package: shared trit encoding, word types and opcode enumeration for
// the ternary core. Assumes the two-bit trit code given in the brief.
package tern_pkg;
    localparam int TW    = 2;          // bits per trit
    localparam int DW    = 4;          // register width
    localparam int IW    = 3 * TW;     // instruction width
    localparam int NSLOT = 3;          // program slots

    typedef logic [TW-1:0]        trit_t;
    typedef logic signed [DW-1:0] word_t;
    typedef logic [IW-1:0]        instr_t;

    localparam trit_t T_NEG  = 2'b11;
    localparam trit_t T_ZERO = 2'b00;
    localparam trit_t T_POS  = 2'b01;
    localparam trit_t T_BAD  = 2'b10;

    typedef enum logic [1:0] {OP_CMP, OP_LWI, OP_BR, OP_BAD} op_e;

    // Value of a trit code as a signed word (invalid code reads as 0)
    function automatic word_t trit_val(trit_t t);
        case (t)
            T_NEG:   trit_val = -4'sd1;
            T_POS:   trit_val = 4'sd1;
            default: trit_val = 4'sd0;
        endcase
    endfunction

    // Trit code of a value in -1..+1
    function automatic trit_t val_trit(word_t v);
        if (v < 0)      val_trit = T_NEG;
        else if (v > 0) val_trit = T_POS;
        else            val_trit = T_ZERO;
    endfunction
endpackage

// File: rtl/tern_imem.sv
// Module: three-slot instruction store indexed by a trit address.
// Assumes the caller has already qualified the write (reset-only, valid codes).
module tern_imem
    import tern_pkg::*;
#(
    parameter int SLOTS = NSLOT
) (
    input  logic   clk,
    input  logic   wr_en,
    input  trit_t  wr_addr,
    input  instr_t wr_data,
    input  trit_t  rd_addr,
    output instr_t rd_data
);
    localparam int AW = $clog2(SLOTS);

    instr_t slot_q [SLOTS];

    // Slot index = trit value + 1
    function automatic logic [AW-1:0] slot_of(trit_t t);
        case (t)
            T_NEG:   slot_of = AW'(0);
            T_POS:   slot_of = AW'(2);
            default: slot_of = AW'(1);
        endcase
    endfunction

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Store the word when this slot is addressed
        always_ff @(posedge clk) begin
            if (wr_en && slot_of(wr_addr) == AW'(g))
                slot_q[g] <= wr_data;
        end
    end

    // Read the slot the PC points at
    assign rd_data = slot_q[slot_of(rd_addr)];
endmodule

// File: rtl/tern_decode.sv
// Module: splits an instruction word into opcode, operand fields and the
// load-immediate value. Assumes stored words contain only valid trit codes.
module tern_decode
    import tern_pkg::*;
(
    input  instr_t instr,
    output op_e    op,
    output trit_t  fld1,
    output trit_t  fld2,
    output word_t  imm
);
    // Opcode trit to operation
    always_comb begin
        case (instr[IW-1 -: TW])
            T_NEG:   op = OP_CMP;
            T_ZERO:  op = OP_LWI;
            T_POS:   op = OP_BR;
            default: op = OP_BAD;
        endcase
    end

    assign fld1 = instr[2*TW-1 -: TW];
    assign fld2 = instr[TW-1:0];
    // Immediate: 3*field1 + field2
    assign imm  = (trit_val(fld1) <<< 1) + trit_val(fld1) + trit_val(fld2);
endmodule

// File: rtl/tern_cmp.sv
// Module: signed three-way comparison returning a status trit.
module tern_cmp
    import tern_pkg::*;
(
    input  word_t lhs,
    input  word_t rhs,
    output trit_t rel
);
    // Less -> -1, greater -> +1, equal -> 0
    always_comb begin
        if (lhs < rhs)      rel = T_NEG;
        else if (lhs > rhs) rel = T_POS;
        else                rel = T_ZERO;
    end
endmodule

// File: rtl/tern_pcnext.sv
// Module: next program counter for sequential advance or two-way branch,
// with any value above +1 wrapped to -1. Assumes PC holds a valid code.
module tern_pcnext
    import tern_pkg::*;
(
    input  trit_t pc_cur,
    input  op_e   op,
    input  trit_t stat,
    input  trit_t fld1,
    input  trit_t fld2,
    output trit_t pc_nxt
);
    word_t raw;

    // Raw target before wrapping
    always_comb begin
        case (op)
            OP_CMP, OP_LWI: raw = trit_val(pc_cur) + 4'sd1;
            OP_BR:          raw = (stat == T_ZERO) ? trit_val(fld1) : trit_val(fld2);
            default:        raw = trit_val(pc_cur);
        endcase
    end

    // Wrap anything past +1 back to -1
    assign pc_nxt = (raw > 4'sd1) ? T_NEG : val_trit(raw);
endmodule

// File: rtl/tern_core.sv
// Module: top of the balanced ternary core. Holds IN, OUT, A, S and PC,
// gates program loading to reset, and executes one instruction per step.
// Assumes step is a single-cycle pulse and rst_n is synchronous.
module tern_core
    import tern_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       in_we,
    input  logic [3:0] in_val,
    input  logic       pm_we,
    input  logic [1:0] pm_addr,
    input  logic [5:0] pm_data,
    output logic       pm_err,
    output logic [3:0] reg_in,
    output logic [3:0] reg_out,
    output logic [3:0] reg_a,
    output logic [1:0] reg_s,
    output logic [1:0] pc
);
    localparam word_t VMAX = 4'sd4;
    localparam word_t VMIN = -4'sd4;

    word_t  in_q, out_q, a_q;
    trit_t  s_q, pc_q;
    logic   err_q;
    instr_t cur;
    op_e    op;
    trit_t  fld1, fld2, rel, pc_nx;
    word_t  imm, opa, opb;
    logic   code_bad, load_ok, in_ok;

    // Any invalid trit code in the load address or word
    assign code_bad = (pm_addr == T_BAD) || (pm_data[5:4] == T_BAD) ||
                      (pm_data[3:2] == T_BAD) || (pm_data[1:0] == T_BAD);
    assign load_ok  = pm_we && !rst_n && !code_bad;
    assign in_ok    = ($signed(in_val) >= VMIN) && ($signed(in_val) <= VMAX);

    tern_imem #(.SLOTS(NSLOT)) u_mem (
        .clk     (clk),
        .wr_en   (load_ok),
        .wr_addr (pm_addr),
        .wr_data (pm_data),
        .rd_addr (pc_q),
        .rd_data (cur)
    );

    tern_decode u_dec (
        .instr (cur),
        .op    (op),
        .fld1  (fld1),
        .fld2  (fld2),
        .imm   (imm)
    );

    // Register selected by field1
    always_comb begin
        case (fld1)
            T_NEG:   opa = in_q;
            T_POS:   opa = a_q;
            default: opa = out_q;
        endcase
    end

    // Register selected by field2
    always_comb begin
        case (fld2)
            T_NEG:   opb = in_q;
            T_POS:   opb = a_q;
            default: opb = out_q;
        endcase
    end

    tern_cmp u_cmp (
        .lhs (opa),
        .rhs (opb),
        .rel (rel)
    );

    tern_pcnext u_pcn (
        .pc_cur (pc_q),
        .op     (op),
        .stat   (s_q),
        .fld1   (fld1),
        .fld2   (fld2),
        .pc_nxt (pc_nx)
    );

    // Load error flag reflects the previous cycle's load attempt
    always_ff @(posedge clk) begin
        err_q <= pm_we && !rst_n && code_bad;
    end

    // External input register with range filter
    always_ff @(posedge clk) begin
        if (!rst_n)              in_q <= '0;
        else if (in_we && in_ok) in_q <= word_t'(in_val);
    end

    // Output register: cleared by reset, written by no instruction
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
    end

    // Architectural state update on a step pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= T_ZERO;
            s_q  <= T_POS;
            a_q  <= '0;
        end else if (step) begin
            pc_q <= pc_nx;
            case (op)
                OP_CMP:  s_q <= rel;
                OP_LWI:  a_q <= imm;
                default: ;
            endcase
        end
    end

    assign pm_err  = err_q;
    assign reg_in  = in_q;
    assign reg_out = out_q;
    assign reg_a   = a_q;
    assign reg_s   = s_q;
    assign pc      = pc_q;
endmodule

// File: rtl/tern_core_chk.sv
// Module: property checker for tern_core, attached by bind. Observes only
// the top-level ports.
module tern_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       step,
    input logic       in_we,
    input logic [3:0] in_val,
    input logic       pm_we,
    input logic [1:0] pm_addr,
    input logic [5:0] pm_data,
    input logic       pm_err,
    input logic [3:0] reg_in,
    input logic [3:0] reg_out,
    input logic [3:0] reg_a,
    input logic [1:0] reg_s,
    input logic [1:0] pc
);
    AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $signed(reg_in) >= -4 && $signed(reg_in) <= 4); // R2
    AST_IN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_we && ($signed(in_val) > 4 || $signed(in_val) < -4)) |=> $stable(reg_in)); // R2
    AST_NO_RUN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> !pm_err); // R4
    AST_S_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_s != 2'b10); // R5
    AST_A_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $signed(reg_a) >= -4 && $signed(reg_a) <= 4); // R6
    AST_PC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        pc != 2'b10); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pc) && $stable(reg_a) && $stable(reg_s)); // R9
    AST_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_out == 4'd0); // R9
endmodule

bind tern_core tern_core_chk u_chk (.*);

// File: tb/sim_tern_core.sv
`timescale 1ns/1ps
module sim_tern_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step = 1'b0;
    logic       in_we = 1'b0;
    logic [3:0] in_val = 4'd0;
    logic       pm_we = 1'b0;
    logic [1:0] pm_addr = 2'b00;
    logic [5:0] pm_data = 6'd0;
    logic       pm_err;
    logic [3:0] reg_in, reg_out, reg_a;
    logic [1:0] reg_s, pc;

    int checks = 0;
    int errors = 0;
    int seed = 12345;
    bit started = 0;
    bit done = 0;

    // Reference state, as integers
    int m_pc, m_s, m_a, m_out, m_in, m_err;
    logic [5:0] m_mem [3];

    always #2.5 clk = ~clk;

    tern_core u0 (
        .clk(clk), .rst_n(rst_n), .step(step), .in_we(in_we), .in_val(in_val),
        .pm_we(pm_we), .pm_addr(pm_addr), .pm_data(pm_data), .pm_err(pm_err),
        .reg_in(reg_in), .reg_out(reg_out), .reg_a(reg_a), .reg_s(reg_s), .pc(pc)
    );

    function automatic int t2i(logic [1:0] c);
        if (c == 2'b11) return -1;
        if (c == 2'b01) return 1;
        return 0;
    endfunction

    function automatic logic [1:0] i2t(int v);
        if (v < 0) return 2'b11;
        if (v > 0) return 2'b01;
        return 2'b00;
    endfunction

    function automatic int sx4(logic [3:0] v);
        return (v[3]) ? int'(v) - 16 : int'(v);
    endfunction

    function automatic int rd(int sel);
        if (sel < 0) return m_in;
        if (sel > 0) return m_a;
        return m_out;
    endfunction

    function automatic int rnd(int n);
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 16) & 32'h7fff) % n;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference updated at each rising edge
    always @(posedge clk) begin
        int op, f1, f2, nxt, bad;
        bad = (pm_addr == 2'b10) || (pm_data[5:4] == 2'b10) ||
              (pm_data[3:2] == 2'b10) || (pm_data[1:0] == 2'b10);
        m_err = (pm_we && !rst_n && bad) ? 1 : 0;
        if (!rst_n) begin
            m_pc = 0; m_s = 1; m_a = 0; m_out = 0; m_in = 0;
            if (pm_we && !bad) m_mem[t2i(pm_addr) + 1] = pm_data;
        end else begin
            if (step) begin
                op = t2i(m_mem[m_pc + 1][5:4]);
                f1 = t2i(m_mem[m_pc + 1][3:2]);
                f2 = t2i(m_mem[m_pc + 1][1:0]);
                if (op < 0) begin
                    m_s = (rd(f1) < rd(f2)) ? -1 : (rd(f1) > rd(f2)) ? 1 : 0;
                    nxt = m_pc + 1;
                end else if (op == 0) begin
                    m_a = 3 * f1 + f2;
                    nxt = m_pc + 1;
                end else begin
                    nxt = (m_s == 0) ? f1 : f2;
                end
                m_pc = (nxt > 1) ? -1 : nxt;
            end
            if (in_we && sx4(in_val) >= -4 && sx4(in_val) <= 4) m_in = sx4(in_val);
        end
    end

    // Compare every port with the reference away from the rising edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R7", "pc",     t2i(pc),      m_pc);
            chk("R5", "S",      t2i(reg_s),   m_s);
            chk("R6", "A",      sx4(reg_a),   m_a);
            chk("R2", "IN",     sx4(reg_in),  m_in);
            chk("R9", "OUT",    sx4(reg_out), m_out);
            chk("R4", "pm_err", int'(pm_err), m_err);
        end
    end

    task automatic load(int addr, logic [5:0] w);
        pm_we = 1'b1; pm_addr = i2t(addr); pm_data = w;
        @(negedge clk);
        pm_we = 1'b0;
    endtask

    function automatic logic [5:0] ins(int op, int a, int b);
        return {i2t(op), i2t(a), i2t(b)};
    endfunction

    task automatic pulse_step();
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    // Watchdog: a hung run still reaches the summary line
    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        started = 1;
        // Directed program: three loads of 1, 2, 3
        load(-1, ins(0, 0, 1));
        load(0,  ins(0, 1, -1));
        load(1,  ins(0, 1, 0));
        // R4: invalid code, must flag and not store
        load(0, 6'b10_00_01);
        chk("R4", "pm_err after bad load", int'(pm_err), 1);
        load(2'b10 == 2'b10 ? 0 : 0, ins(0, 1, -1));
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset
        chk("R1", "pc", t2i(pc), 0);
        chk("R1", "S",  t2i(reg_s), 1);
        chk("R1", "A",  sx4(reg_a), 0);
        chk("R1", "IN", sx4(reg_in), 0);
        // R3: write while running must be ignored
        load(0, ins(0, -1, -1));
        pulse_step();
        chk("R3", "A from slot 0", sx4(reg_a), 2);
        chk("R8", "pc after 0", t2i(pc), 1);
        pulse_step();
        chk("R8", "pc wraps to -1", t2i(pc), -1);
        pulse_step();
        chk("R8", "pc back to 0", t2i(pc), 0);
        chk("R6", "A from slot -1", sx4(reg_a), 1);
        repeat (3) @(negedge clk);
        chk("R9", "A held idle", sx4(reg_a), 1);
        chk("R9", "pc held idle", t2i(pc), 0);
        // R2: IN range filter
        in_we = 1'b1; in_val = 4'd7; @(negedge clk);
        chk("R2", "IN reject 7", sx4(reg_in), 0);
        in_val = 4'hC; @(negedge clk);
        chk("R2", "IN accept -4", sx4(reg_in), -4);
        in_val = 4'h8; @(negedge clk);
        chk("R2", "IN reject -8", sx4(reg_in), -4);
        in_we = 1'b0;
        // Directed branch: cmp IN,A then branch on equal
        rst_n = 1'b0;
        load(0, ins(-1, -1, 1));
        load(1, ins(1, -1, 0));
        load(-1, ins(0, 1, 1));
        rst_n = 1'b1;
        @(negedge clk);
        pulse_step();
        chk("R5", "S equal", t2i(reg_s), 0);
        pulse_step();
        chk("R7", "branch taken to field1", t2i(pc), -1);
        pulse_step();
        chk("R6", "A = 4", sx4(reg_a), 4);
        pulse_step();
        chk("R5", "S less", t2i(reg_s), -1);
        pulse_step();
        chk("R7", "branch to field2", t2i(pc), 0);
        // Random programs and stimulus
        for (int p = 0; p < 30; p++) begin
            rst_n = 1'b0;
            for (int s = -1; s <= 1; s++)
                load(s, ins(rnd(3) - 1, rnd(3) - 1, rnd(3) - 1));
            if (rnd(2) == 1) load(rnd(3) - 1, 6'(rnd(64)));
            rst_n = 1'b1;
            for (int c = 0; c < 80; c++) begin
                step   = (rnd(3) != 0);
                in_we  = (rnd(2) == 1);
                in_val = 4'(rnd(16));
                pm_we  = (rnd(8) == 0);
                pm_addr = 2'(rnd(4));
                pm_data = 6'(rnd(64));
                @(negedge clk);
            end
            step = 1'b0; in_we = 1'b0; pm_we = 1'b0;
        end
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule